// File: doc/BRIEF.md
# Volts-per-Hertz Command Calculator

This block turns a pair of 10-bit converter readings into the two set-points a sine modulator needs. One reading comes from a speed knob and becomes a frequency word. The other sets the slope of the voltage-versus-frequency line and becomes a fractional amplitude. A single `pair_valid` strobe marks each new pair. The pair is captured, scaled and limited in a short pipeline.

The frequency word is the speed reading with its two least significant bits dropped. One step of the word is about 0.244 Hz, so the top of the range is roughly 62 Hz. Both readings are left-aligned into unsigned Q15 fractions, where 0x7FFF is just under one. Their product is the amplitude, running from 0 to nearly 100 % of the modulation voltage. A full slope reading gives the steepest profile. The product is clipped to a configurable ceiling so that the modulator is never driven into overmodulation.

In a drive, the readings arrive once per update, typically a few hundred times a second. Between updates both commands stay at their last values.

Top module: `vf_command_calc`

## Requirements
- R1: While `rst` is high at a rising clock edge, and after that edge until the first accepted pair has passed through, `freq_cmd` and `amp_cmd` are zero.
- R2: `freq_cmd` equals bits [9:2] of the accepted `speed_raw`, which is the reading shifted right by two.
- R3: Each reading r is aligned to Q15 as r·32, with the sign bit zero. The amplitude before limiting is (speed·32 · slope·32) >> 15, truncated.
- R4: When that product exceeds `AMP_LIMIT` (default 29491), `amp_cmd` equals `AMP_LIMIT`. The limit is applied after the multiply.
- R5: When `pair_valid` is low, changes on `speed_raw` and `slope_raw` have no effect. Both outputs hold their values.
- R6: A pair sampled with `pair_valid` high at edge k shows on both outputs together after edge k+1. The outputs do not change after edge k.
- R7: Pairs on consecutive cycles are each taken in turn. Each one appears on the outputs one cycle after the one before.
- R8: `amp_cmd` never exceeds `AMP_LIMIT`.
- R9: A zero speed reading or a zero slope reading gives zero amplitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pair_valid | input | 1 | Marks a new reading pair for one cycle |
| speed_raw | input | 10 | Speed knob reading |
| slope_raw | input | 10 | V/F slope knob reading |
| freq_cmd | output | 8 | Frequency command word |
| amp_cmd | output | 16 | Limited Q15 amplitude command |

## Verification
The bench uses the following reading pairs:
- Full scale on both knobs. This tells a working clamp from a raw product that slips past the limit.
- A mid-scale speed against a full slope. This lands below the limit and exposes errors in alignment or in the product slice.
- Zero on either knob. This separates the frequency path from the amplitude path.
- Pairs whose product sits just below and just above the ceiling. These pin the direction of the comparison.
- Knob changes with the strobe low, and strobes on back-to-back cycles. These show whether capture is gated and whether pipeline timing holds.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
    localparam int ADC_W      = 10;
    localparam int FREQ_SHIFT = 2;
    localparam int Q_W        = 16;
    localparam int FREQ_W     = ADC_W - FREQ_SHIFT;
    localparam int ALIGN_SH   = Q_W - 1 - ADC_W;
    localparam int PROD_W     = 2 * Q_W;

    typedef logic [ADC_W-1:0]  adc_t;
    typedef logic [FREQ_W-1:0] freq_t;
    typedef logic [Q_W-1:0]    q15_t;

    typedef struct packed {
        adc_t speed;
        adc_t slope;
    } adc_pair_t;

    typedef struct packed {
        freq_t freq;
        q15_t  amp;
    } vf_cmd_t;

    // left-align a reading as a non-negative Q15 fraction
    function automatic q15_t to_q15(adc_t r);
        return {1'b0, r, {ALIGN_SH{1'b0}}};
    endfunction

    // Q15 x Q15 -> Q15, both operands non-negative
    function automatic q15_t q15_mul(q15_t a, q15_t b);
        logic [PROD_W-1:0] p;
        p = PROD_W'(a) * PROD_W'(b);
        return p[Q_W-1 +: Q_W];
    endfunction

    function automatic freq_t speed_to_freq(adc_t r);
        return r[ADC_W-1:FREQ_SHIFT];
    endfunction
endpackage

// File: rtl/vfc_scale.sv
module vfc_scale
    import vfc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  adc_pair_t in_pair,
    output logic      out_valid,
    output vf_cmd_t   out_raw
);
    vf_cmd_t next_cmd;

    always_comb begin
        next_cmd.freq = speed_to_freq(in_pair.speed);
        next_cmd.amp  = q15_mul(to_q15(in_pair.speed), to_q15(in_pair.slope));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_raw   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_raw <= next_cmd;
        end
    end
endmodule

// File: rtl/vfc_limit.sv
module vfc_limit
    import vfc_pkg::*;
#(
    parameter q15_t AMP_LIMIT = 16'd29491
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  vf_cmd_t in_raw,
    output vf_cmd_t out_cmd
);
    vf_cmd_t limited;

    always_comb begin
        limited = in_raw;
        if (in_raw.amp > AMP_LIMIT) limited.amp = AMP_LIMIT;
    end

    always_ff @(posedge clk) begin
        if (rst)           out_cmd <= '0;
        else if (in_valid) out_cmd <= limited;
    end
endmodule

// File: rtl/vf_command_calc.sv
module vf_command_calc
    import vfc_pkg::*;
#(
    parameter logic [15:0] AMP_LIMIT = 16'd29491
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pair_valid,
    input  logic [9:0]  speed_raw,
    input  logic [9:0]  slope_raw,
    output logic [7:0]  freq_cmd,
    output logic [15:0] amp_cmd
);
    adc_pair_t pair_in;
    logic      mid_valid;
    vf_cmd_t   mid_raw;
    vf_cmd_t   cmd_q;

    assign pair_in.speed = speed_raw;
    assign pair_in.slope = slope_raw;

    vfc_scale u_scale (
        .clk      (clk),
        .rst      (rst),
        .in_valid (pair_valid),
        .in_pair  (pair_in),
        .out_valid(mid_valid),
        .out_raw  (mid_raw)
    );

    vfc_limit #(.AMP_LIMIT(AMP_LIMIT)) u_limit (
        .clk     (clk),
        .rst     (rst),
        .in_valid(mid_valid),
        .in_raw  (mid_raw),
        .out_cmd (cmd_q)
    );

    assign freq_cmd = cmd_q.freq;
    assign amp_cmd  = cmd_q.amp;
endmodule

// File: rtl/vfc_checker.sv
module vfc_checker #(
    parameter logic [15:0] LIM = 16'd29491
) (
    input logic        clk,
    input logic        rst,
    input logic        pair_valid,
    input logic [9:0]  speed_raw,
    input logic [9:0]  slope_raw,
    input logic [7:0]  freq_cmd,
    input logic [15:0] amp_cmd
);
    // R8: amplitude stays within the ceiling
    a_r8_amp_ceiling: assert property (@(posedge clk) disable iff (rst)
        amp_cmd <= LIM);

    // R5: no strobe, no change two edges later
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !pair_valid |=> ##1 ($stable(freq_cmd) && $stable(amp_cmd)));

    // R2: frequency word is the top eight bits of the accepted speed reading
    a_r2_freq_shift: assert property (@(posedge clk) disable iff (rst)
        pair_valid |-> ##2 (freq_cmd == $past(speed_raw[9:2], 2)));

    // R9: a zero knob gives zero amplitude
    a_r9_zero_amp: assert property (@(posedge clk) disable iff (rst)
        (pair_valid && (speed_raw == 10'd0 || slope_raw == 10'd0)) |-> ##2 (amp_cmd == 16'd0));
endmodule

bind vf_command_calc vfc_checker #(.LIM(AMP_LIMIT)) u_vfc_checker (
    .clk       (clk),
    .rst       (rst),
    .pair_valid(pair_valid),
    .speed_raw (speed_raw),
    .slope_raw (slope_raw),
    .freq_cmd  (freq_cmd),
    .amp_cmd   (amp_cmd)
);

// File: tb/vf_command_calc_test.sv
`timescale 1ns/100ps
module vf_command_calc_test;
    localparam int LIMIT = 29491;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pair_valid = 1'b0;
    logic [9:0]  speed_raw = '0;
    logic [9:0]  slope_raw = '0;
    logic [7:0]  freq_cmd;
    logic [15:0] amp_cmd;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int exp_f = 0;
    int exp_a = 0;

    always #2.5 clk = ~clk;

    vf_command_calc uut (
        .clk(clk), .rst(rst), .pair_valid(pair_valid),
        .speed_raw(speed_raw), .slope_raw(slope_raw),
        .freq_cmd(freq_cmd), .amp_cmd(amp_cmd)
    );

    function automatic int calc_amp(int s, int l);
        longint p;
        p = (longint'(s * 32) * longint'(l * 32)) >>> 15;
        if (p > LIMIT) p = LIMIT;
        return int'(p);
    endfunction

    task automatic check(string req, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // drive one pair, check it is not visible early, then check the result
    task automatic apply(string req, int s, int l);
        @(negedge clk);
        speed_raw = 10'(s); slope_raw = 10'(l); pair_valid = 1'b1;
        @(negedge clk);
        pair_valid = 1'b0;
        check("R6 freq early", freq_cmd, exp_f);
        check("R6 amp early", amp_cmd, exp_a);
        @(negedge clk);
        exp_f = s >> 2;
        exp_a = calc_amp(s, l);
        check({req, " freq R2"}, freq_cmd, exp_f);
        check({req, " amp"}, amp_cmd, exp_a);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 freq", freq_cmd, 0);
        check("R1 amp", amp_cmd, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 freq after release", freq_cmd, 0);
    endtask

    task automatic t_mid();
        apply("R3 mid", 512, 1023);
        check("R3 mid value", amp_cmd, 16368);
    endtask

    task automatic t_full();
        apply("R4 full", 1023, 1023);
        check("R4 clamp", amp_cmd, LIMIT);
        check("R8 ceiling", (amp_cmd <= LIMIT) ? 1 : 0, 1);
    endtask

    task automatic t_zero();
        apply("R9 zero speed", 0, 800);
        check("R9 zero speed amp", amp_cmd, 0);
        apply("R9 zero slope", 777, 0);
        check("R9 zero slope amp", amp_cmd, 0);
        check("R2 zero slope freq", freq_cmd, 194);
    endtask

    task automatic t_edge();
        // 960*32=30720; 30720*30720>>15 = 28800 (below limit)
        apply("R3 below limit", 960, 960);
        check("R3 below", amp_cmd, 28800);
        // 1000*32=32000; 32000*32000>>15 = 31250 (above limit)
        apply("R4 above limit", 1000, 1000);
        check("R4 above", amp_cmd, LIMIT);
    endtask

    task automatic t_hold();
        apply("R5 base", 300, 600);
        @(negedge clk);
        speed_raw = 10'd1000; slope_raw = 10'd50;
        repeat (4) @(negedge clk);
        check("R5 hold freq", freq_cmd, exp_f);
        check("R5 hold amp", amp_cmd, exp_a);
    endtask

    task automatic t_b2b();
        @(negedge clk);
        speed_raw = 10'd400; slope_raw = 10'd900; pair_valid = 1'b1;
        @(negedge clk);
        speed_raw = 10'd100; slope_raw = 10'd200;
        @(negedge clk);
        pair_valid = 1'b0;
        check("R7 first freq", freq_cmd, 100);
        check("R7 first amp", amp_cmd, calc_amp(400, 900));
        @(negedge clk);
        check("R7 second freq", freq_cmd, 25);
        check("R7 second amp", amp_cmd, calc_amp(100, 200));
        exp_f = 25; exp_a = calc_amp(100, 200);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_mid();
        t_full();
        t_zero();
        t_edge();
        t_hold();
        t_b2b();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule